// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Sticky Saturation Flag

This block performs signed 32-bit saturating arithmetic on two operands in one clock. A 2-bit operation code selects one of four operations:

- plain add;
- plain subtract;
- add with the second operand doubled first;
- subtract with the second operand doubled first.

The doubling step saturates on its own. The add or subtract then saturates again. Saturation at either step raises a one-cycle pulse. The pulse also sets a sticky flag that the block holds.

Results and the pulse are registered on a clock edge where the valid strobe is high. The sticky flag stays set through later operations that do not saturate. A dedicated clear input, driven when software writes the status word, drops the flag. A set in the same cycle as a clear takes priority.

The flag is a two-state machine. Its states are `FLAG_LOW` and `FLAG_HIGH`, and it has three named transitions:

- `SET`: `FLAG_LOW` to `FLAG_HIGH`, taken on a valid operation that saturates.
- `CLEAR`: `FLAG_HIGH` to `FLAG_LOW`, taken on `flag_clr` with no saturation in that cycle.
- `HOLD`: the state stays the same in every other case.

Top module: `sat_addsub_unit`

## Requirements
- R1: After synchronous reset, `result` is 0, `sat_pulse` is 0 and `sat_flag` is 0.
- R2: With `op` = 2'b00 and `in_valid` high, `result` becomes `opnd_a + opnd_b`. The sum is clamped to 0x7FFF_FFFF on positive overflow and to 0x8000_0000 on negative overflow. The value is visible in the cycle after the edge.
- R3: With `op` = 2'b01, `result` becomes `opnd_a - opnd_b`, saturated to the same two bounds.
- R4: With `op[1]` = 1, `opnd_b` is first doubled with signed saturation. The add (`op` = 2'b10) or subtract (`op` = 2'b11) then uses the doubled value and saturates again.
- R5: Saturation of the doubling step alone raises `sat_pulse` and sets `sat_flag`, even when the final add or subtract stays in range.
- R6: Saturation is detected from the operand and result signs. A true result equal to 0x7FFF_FFFF or 0x8000_0000 raises neither `sat_pulse` nor `sat_flag`.
- R7: Once set, `sat_flag` stays 1 through later valid operations that do not saturate. `sat_pulse` is high only in the cycle after a saturating operation.
- R8: `flag_clr` clears `sat_flag` on the next edge. If a saturating valid operation arrives in the same cycle, the flag is set instead.
- R9: With `in_valid` low, `result` holds its value, `sat_pulse` is 0 and `sat_flag` changes only through `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | bit 1: double second operand; bit 0: subtract |
| opnd_a | input | 32 | First signed operand |
| opnd_b | input | 32 | Second signed operand (the one doubled) |
| flag_clr | input | 1 | Clears the sticky flag |
| result | output | 32 | Registered saturated result |
| sat_pulse | output | 1 | One-cycle saturation indication |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A saturating operation and a flag clear can arrive in the same cycle. The bench provokes this directly by raising `flag_clr` together with an add that overflows. It also raises `flag_clr` with a non-saturating operation. It then judges the flag in the following cycle: set in the first case, clear in the second. Random traffic also asserts `flag_clr` now and then, so the two events meet at unplanned points. Each outcome is compared against a reference model that puts the set ahead of the clear.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } sat_op_e;

    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;
endpackage

// File: rtl/sat_doubler.sv
module sat_doubler #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    input  logic             enable,
    output logic [WIDTH-1:0] dout,
    output logic             clipped
);
    localparam logic [WIDTH-1:0] POS_BOUND = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_BOUND = {1'b1, {(WIDTH-1){1'b0}}};

    logic over;

    // Doubling overflows when the two top bits differ.
    assign over    = din[WIDTH-1] ^ din[WIDTH-2];
    assign clipped = enable && over;

    always_comb begin
        if (!enable)
            dout = din;
        else if (over)
            dout = din[WIDTH-1] ? NEG_BOUND : POS_BOUND;
        else
            dout = {din[WIDTH-2:0], 1'b0};
    end
endmodule

// File: rtl/sat_adder.sv
module sat_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum,
    output logic             clipped
);
    localparam logic [WIDTH-1:0] POS_BOUND = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_BOUND = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] raw;
    logic             same_in;
    logic             flipped;

    assign raw     = subtract ? (lhs - rhs) : (lhs + rhs);
    // Add overflows on equal signs; subtract overflows on opposite signs.
    assign same_in = (lhs[WIDTH-1] == rhs[WIDTH-1]);
    assign flipped = (raw[WIDTH-1] != lhs[WIDTH-1]);
    assign clipped = flipped && (subtract ? !same_in : same_in);

    always_comb begin
        if (clipped)
            sum = lhs[WIDTH-1] ? NEG_BOUND : POS_BOUND;
        else
            sum = raw;
    end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag
    import sat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    // Next state: set wins over clear.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW:  if (set_req) state_d = FLAG_HIGH;
            FLAG_HIGH: if (clr_req && !set_req) state_d = FLAG_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= FLAG_LOW;
        else
            state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLAG_HIGH);
    end
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
    import sat_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] result,
    output logic             sat_pulse,
    output logic             sat_flag
);
    sat_op_e          op_e;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             dbl_clip;
    logic             add_clip;
    logic             any_clip;

    assign op_e     = sat_op_e'(op);
    assign any_clip = dbl_clip || add_clip;

    sat_doubler #(.WIDTH(WIDTH)) u_dbl (
        .din     (opnd_b),
        .enable  (op_e == OP_DADD || op_e == OP_DSUB),
        .dout    (b_eff),
        .clipped (dbl_clip)
    );

    sat_adder #(.WIDTH(WIDTH)) u_add (
        .lhs      (opnd_a),
        .rhs      (b_eff),
        .subtract (op_e == OP_SUB || op_e == OP_DSUB),
        .sum      (sum),
        .clipped  (add_clip)
    );

    sticky_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (in_valid && any_clip),
        .clr_req (flag_clr),
        .flag    (sat_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            sat_pulse <= 1'b0;
        end else begin
            sat_pulse <= in_valid && any_clip;
            if (in_valid)
                result <= sum;
        end
    end
endmodule

// File: rtl/sat_addsub_unit_chk.sv
module sat_addsub_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       op,
    input logic             flag_clr,
    input logic [WIDTH-1:0] result,
    input logic             sat_pulse,
    input logic             sat_flag
);
    localparam logic [WIDTH-1:0] POS_BOUND = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_BOUND = {1'b1, {(WIDTH-1){1'b0}}};

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (result == '0 && !sat_pulse && !sat_flag));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op[1]) |=> (!sat_pulse || result == POS_BOUND || result == NEG_BOUND));

    assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        sat_pulse |-> sat_flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !flag_clr) |=> sat_flag);

    assert_clear_or_set_R8: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> (sat_flag == sat_pulse));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && !sat_pulse));
endmodule

bind sat_addsub_unit sat_addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .flag_clr  (flag_clr),
    .result    (result),
    .sat_pulse (sat_pulse),
    .sat_flag  (sat_flag)
);

// File: tb/sat_addsub_unit_tb_top.sv
module sat_addsub_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        flag_clr;
    logic [31:0] result;
    logic        sat_pulse;
    logic        sat_flag;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] exp_result;
    logic        exp_pulse;
    logic        exp_flag;

    always #2.5 clk = ~clk;

    sat_addsub_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .flag_clr  (flag_clr),
        .result    (result),
        .sat_pulse (sat_pulse),
        .sat_flag  (sat_flag)
    );

    function automatic logic [31:0] clamp64(input longint v, output logic hit);
        hit = 1'b0;
        if (v > 64'sd2147483647) begin
            hit = 1'b1;
            return 32'h7FFF_FFFF;
        end
        if (v < -64'sd2147483648) begin
            hit = 1'b1;
            return 32'h8000_0000;
        end
        return v[31:0];
    endfunction

    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] o,
                         output logic [31:0] r, output logic s);
        longint sa;
        longint sb;
        logic   h1;
        logic   h2;
        logic [31:0] beff;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        h1 = 1'b0;
        if (o[1]) begin
            beff = clamp64(sb * 2, h1);
            sb   = longint'($signed(beff));
        end
        r = clamp64(o[0] ? sa - sb : sa + sb, h2);
        s = h1 | h2;
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "result", result, exp_result);
        check(req, "sat_pulse", {31'b0, sat_pulse}, {31'b0, exp_pulse});
        check(req, "sat_flag", {31'b0, sat_flag}, {31'b0, exp_flag});
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic v, input logic [1:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic c, input string req);
        logic [31:0] r;
        logic        s;
        in_valid = v;
        op       = o;
        opnd_a   = a;
        opnd_b   = b;
        flag_clr = c;
        model(a, b, o, r, s);
        @(negedge clk);
        if (v) exp_result = r;
        exp_pulse = v && s;
        if (v && s) exp_flag = 1'b1;
        else if (c) exp_flag = 1'b0;
        check_all(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        rst = 1'b1;
        in_valid = 1'b0;
        op = 2'b00;
        opnd_a = '0;
        opnd_b = '0;
        flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        exp_result = '0;
        exp_pulse = 1'b0;
        exp_flag = 1'b0;
        check_all("R1");
        rst = 1'b0;

        step(1, 2'b00, 32'd5, 32'd7, 0, "R2");
        step(1, 2'b00, 32'h7FFF_FFFF, 32'd1, 0, "R2");
        step(0, 2'b00, 32'd1, 32'd1, 1, "R8");
        step(1, 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R2");
        step(0, 2'b00, 32'd0, 32'd0, 1, "R8");
        step(1, 2'b01, 32'd10, 32'd3, 0, "R3");
        step(1, 2'b01, 32'h8000_0000, 32'd1, 0, "R3");
        step(1, 2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
        step(1, 2'b00, 32'd1, 32'd2, 0, "R7");
        step(0, 2'b11, 32'hDEAD_BEEF, 32'h1234_5678, 0, "R9");
        step(0, 2'b00, 32'd0, 32'd0, 1, "R8");
        step(1, 2'b10, 32'd5, 32'd3, 0, "R4");
        step(1, 2'b11, 32'd5, 32'hFFFF_FFFD, 0, "R4");
        step(1, 2'b10, 32'hFFFF_FFFF, 32'h4000_0000, 0, "R5");
        step(0, 2'b00, 32'd0, 32'd0, 1, "R8");
        step(1, 2'b11, 32'd0, 32'h8000_0000, 0, "R5");
        step(0, 2'b00, 32'd0, 32'd0, 1, "R8");
        step(1, 2'b00, 32'h7FFF_FFFE, 32'd1, 0, "R6");
        step(1, 2'b01, 32'h8000_0001, 32'd1, 0, "R6");
        step(1, 2'b10, 32'h0000_0001, 32'h3FFF_FFFF, 0, "R6");
        step(1, 2'b00, 32'h7FFF_FFF0, 32'h100, 1, "R8");
        step(1, 2'b00, 32'd1, 32'd1, 1, "R8");
        step(1, 2'b10, 32'h7FFF_FFFF, 32'd1, 0, "R7");
        step(1, 2'b01, 32'd9, 32'd4, 0, "R7");
        step(0, 2'b00, 32'h5555_5555, 32'h5555_5555, 0, "R9");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = $urandom();
            b = $urandom();
            if (($urandom() % 4) == 0) a = {a[31], 31'h7FFF_FFF0 | a[3:0]};
            step(($urandom() % 5) != 0, 2'($urandom()), a, b, ($urandom() % 6) == 0, "R2");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule